// File: doc/BRIEF.md
# NAND Flash Host Interface Controller

This block sits between a byte-wide host register port and the control and data pins of a raw NAND flash device. The host steers the flash bus by writing one mode byte: its bits drive the command-latch, address-latch, chip-select and write-protect pins directly, and a two-bit field selects an ECC engine command. When that command needs it, the block produces a one-cycle clear strobe for the engine.

Bytes written to the data window go out on the flash output bus with a one-cycle write strobe. Reads from the data window raise a read strobe and return the byte on the flash input bus. A status/mask register pair turns data writes into a host interrupt. The mask register also holds a master enable bit.

The flash device, page buffering and the ECC arithmetic all lie outside the block. The host makes at most one access per cycle. If a write and a read are presented together, the write is taken and the read is dropped.

Top module: `nandc_host_if`

## Requirements
- R1: After reset, CLE, ALE and write-protect are low, the active-low chip enable is high, the interrupt is low, the ECC clear strobe is low, and the mode, interrupt status and interrupt mask registers read back as 0x00.
- R2: A write to offset 4 loads the mode register. From the next cycle, mode bit 0 drives CLE, bit 1 drives ALE, bit 7 drives write-protect, and the chip-enable pin is driven low when bit 4 is set and high when it is clear. A read of offset 4 returns the stored byte.
- R3: A mode write whose bits 6:5 equal 2'b11 (ECC reset) or 2'b01 (ECC enable) raises the ECC clear strobe for exactly the following cycle. The values 2'b10 (ECC read) and 2'b00 raise no strobe. The ecc_cmd output reflects the stored bits 6:5.
- R4: A write to any of offsets 0 to 3 places the byte on the flash output bus, raises the flash write strobe for exactly the following cycle, and sets bit 0 of the interrupt status register.
- R5: A read of any of offsets 0 to 3 raises the flash read strobe during the cycle of the request. The byte present on the flash input bus in that cycle is then returned as read data.
- R6: Offset 5 always reads 0x14. A write to offset 5 changes no register and no pin.
- R7: The interrupt output is high only when interrupt mask bit 7 is set and the bitwise AND of mask and status is nonzero. It reflects a register write from the cycle after that write.
- R8: Offsets 6 (interrupt status) and 7 (interrupt mask) are written directly by the host and read back unchanged. Writing 0x00 to the status register clears a pending interrupt.
- R9: Every read request produces a one-cycle read-valid pulse in the following cycle, with the read data valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write request, one cycle per access |
| host_rd | input | 1 | Host read request, one cycle per access |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid pulse |
| nand_io_out | output | 8 | Byte driven toward the flash I/O bus |
| nand_io_in | input | 8 | Byte presented by the flash I/O bus |
| nand_wr_stb | output | 1 | One-cycle flash write strobe |
| nand_rd_stb | output | 1 | Flash read strobe, high during a data-window read request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_wp | output | 1 | Write-protect control |
| ecc_cmd | output | 2 | Stored ECC command field |
| ecc_clr | output | 1 | One-cycle ECC engine clear strobe |
| host_irq | output | 1 | Controller interrupt |

## Verification
The assertions assume the host raises host_wr or host_rd for one cycle per access. They also assume host_addr and host_wdata are stable and known whenever a request is high. They do not assume the two requests are mutually exclusive: the read-side properties are qualified with the absence of a write, so they still hold when both are raised together.

The stimulus drives every request from the falling edge, holds it for exactly one cycle, and returns both requests low between accesses. It never raises a write and a read together.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_MODE = 3'd4;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_ISR  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_IMR  = 3'd7;

  localparam int MB_CLE   = 0;
  localparam int MB_ALE   = 1;
  localparam int MB_SEL   = 4;
  localparam int MB_ECC   = 5;
  localparam int MB_WP    = 7;
  localparam int IRQ_MSTR = 7;
  localparam int ISR_DATA = 0;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_MODE,
    SEL_STAT,
    SEL_ISR,
    SEL_IMR
  } sel_e;

  function automatic sel_e decode_ofs(input logic [OFS_W-1:0] a);
    if (a[OFS_W-1:2] == '0) return SEL_DATA;
    case (a)
      OFS_MODE: return SEL_MODE;
      OFS_STAT: return SEL_STAT;
      OFS_ISR:  return SEL_ISR;
      default:  return SEL_IMR;
    endcase
  endfunction

  // ECC engine clear is required for the reset (11) and enable (01) commands
  function automatic logic ecc_needs_clear(input logic [1:0] cmd);
    return (cmd == 2'b11) || (cmd == 2'b01);
  endfunction

  function automatic logic irq_level(input logic [BYTE_W-1:0] isr,
                                     input logic [BYTE_W-1:0] imr);
    return imr[IRQ_MSTR] && ((imr & isr) != '0);
  endfunction

endpackage

// File: rtl/nandc_decode.sv
module nandc_decode
  import nandc_pkg::*;
(
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [OFS_W-1:0] host_addr,
  output sel_e             sel,
  output logic             wr_data,
  output logic             wr_mode,
  output logic             wr_isr,
  output logic             wr_imr,
  output logic             rd_take,
  output logic             rd_data
);

  always_comb begin
    sel     = decode_ofs(host_addr);
    wr_data = host_wr && (sel == SEL_DATA);
    wr_mode = host_wr && (sel == SEL_MODE);
    wr_isr  = host_wr && (sel == SEL_ISR);
    wr_imr  = host_wr && (sel == SEL_IMR);
    rd_take = host_rd && !host_wr;
    rd_data = rd_take && (sel == SEL_DATA);
  end

endmodule

// File: rtl/nandc_mode_ctl.sv
module nandc_mode_ctl
  import nandc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_wp,
  output logic [1:0]        ecc_cmd,
  output logic              ecc_clr
);

  logic clr_req;

  assign clr_req = wr_mode && ecc_needs_clear(wdata[MB_ECC+1:MB_ECC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ecc_clr <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      ecc_clr <= clr_req;
    end
  end

  always_comb begin
    nand_cle  = mode_q[MB_CLE];
    nand_ale  = mode_q[MB_ALE];
    nand_ce_n = !mode_q[MB_SEL];
    nand_wp   = mode_q[MB_WP];
    ecc_cmd   = mode_q[MB_ECC+1:MB_ECC];
  end

endmodule

// File: rtl/nandc_irq_ctl.sv
module nandc_irq_ctl
  import nandc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_isr,
  input  logic              wr_imr,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] isr_q,
  output logic [BYTE_W-1:0] imr_q,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      if (wr_isr)       isr_q <= wdata;
      else if (wr_data) isr_q[ISR_DATA] <= 1'b1;
      if (wr_imr)       imr_q <= wdata;
    end
  end

  assign irq = irq_level(isr_q, imr_q);

endmodule

// File: rtl/nandc_data_port.sv
module nandc_data_port
  import nandc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STAT_VALUE = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              rd_take,
  input  sel_e              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] isr_q,
  input  logic [BYTE_W-1:0] imr_q,
  input  logic [BYTE_W-1:0] nand_io_in,
  output logic [BYTE_W-1:0] nand_io_out,
  output logic              nand_wr_stb,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rvalid
);

  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = nand_io_in;
      SEL_MODE: rd_mux = mode_q;
      SEL_STAT: rd_mux = STAT_VALUE;
      SEL_ISR:  rd_mux = isr_q;
      default:  rd_mux = imr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nand_io_out <= '0;
      nand_wr_stb <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      nand_wr_stb <= wr_data;
      if (wr_data) nand_io_out <= wdata;
      host_rvalid <= rd_take;
      if (rd_take) host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/nandc_host_if.sv
module nandc_host_if
  import nandc_pkg::*;
#(
  parameter logic [7:0] STAT_VALUE = 8'h14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic [7:0] nand_io_out,
  input  logic [7:0] nand_io_in,
  output logic       nand_wr_stb,
  output logic       nand_rd_stb,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_ce_n,
  output logic       nand_wp,
  output logic [1:0] ecc_cmd,
  output logic       ecc_clr,
  output logic       host_irq
);

  sel_e              sel;
  logic              wr_data, wr_mode, wr_isr, wr_imr, rd_take, rd_data;
  logic [BYTE_W-1:0] mode_q, isr_q, imr_q;

  nandc_decode u_decode (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .sel       (sel),
    .wr_data   (wr_data),
    .wr_mode   (wr_mode),
    .wr_isr    (wr_isr),
    .wr_imr    (wr_imr),
    .rd_take   (rd_take),
    .rd_data   (rd_data)
  );

  nandc_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .wdata     (host_wdata),
    .mode_q    (mode_q),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_ce_n (nand_ce_n),
    .nand_wp   (nand_wp),
    .ecc_cmd   (ecc_cmd),
    .ecc_clr   (ecc_clr)
  );

  nandc_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_isr  (wr_isr),
    .wr_imr  (wr_imr),
    .wr_data (wr_data),
    .wdata   (host_wdata),
    .isr_q   (isr_q),
    .imr_q   (imr_q),
    .irq     (host_irq)
  );

  nandc_data_port #(.STAT_VALUE(STAT_VALUE)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data     (wr_data),
    .rd_take     (rd_take),
    .sel         (sel),
    .wdata       (host_wdata),
    .mode_q      (mode_q),
    .isr_q       (isr_q),
    .imr_q       (imr_q),
    .nand_io_in  (nand_io_in),
    .nand_io_out (nand_io_out),
    .nand_wr_stb (nand_wr_stb),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  assign nand_rd_stb = rd_data;

endmodule

// File: rtl/nandc_host_if_chk.sv
module nandc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [2:0] host_addr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       host_rvalid,
  input logic [7:0] nand_io_out,
  input logic       nand_wr_stb,
  input logic       nand_rd_stb,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_ce_n,
  input logic       nand_wp,
  input logic       ecc_clr,
  input logic       host_irq,
  input logic [7:0] isr_q
);

  logic in_win;
  assign in_win = (host_addr[2] == 1'b0);

  assert_mode_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd4) |=>
      (nand_cle == $past(host_wdata[0]) && nand_ale == $past(host_wdata[1]) &&
       nand_ce_n == !$past(host_wdata[4]) && nand_wp == $past(host_wdata[7])));

  assert_ecc_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd4 && host_wdata[5]) |=> ecc_clr);

  assert_ecc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |-> $past(host_wr && host_addr == 3'd4 && host_wdata[5]));

  assert_data_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && in_win) |=>
      (nand_wr_stb && nand_io_out == $past(host_wdata) && isr_q[0]));

  assert_rd_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd_stb |-> (host_rd && !host_wr && in_win));

  assert_status_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_addr == 3'd5) |=> (host_rdata == 8'h14));

  assert_master_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd7 && !host_wdata[7]) |=> !host_irq);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);

endmodule

bind nandc_host_if nandc_host_if_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .nand_io_out (nand_io_out),
  .nand_wr_stb (nand_wr_stb),
  .nand_rd_stb (nand_rd_stb),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_ce_n   (nand_ce_n),
  .nand_wp     (nand_wp),
  .ecc_clr     (ecc_clr),
  .host_irq    (host_irq),
  .isr_q       (isr_q)
);

// File: tb/nandc_host_if_bench.sv
module nandc_host_if_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0, nand_io_in = '0;
  logic [7:0] host_rdata, nand_io_out;
  logic       host_rvalid, nand_wr_stb, nand_rd_stb;
  logic       nand_cle, nand_ale, nand_ce_n, nand_wp, ecc_clr, host_irq;
  logic [1:0] ecc_cmd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nandc_host_if u_nandc_host_if (.*);

  // {is_read, offset, data (write byte or flash input byte), expected read}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd4, 8'h93, 8'h00},
    {1'b1, 3'd4, 8'h00, 8'h93},
    {1'b1, 3'd5, 8'h00, 8'h14},
    {1'b0, 3'd7, 8'h81, 8'h00},
    {1'b1, 3'd7, 8'h00, 8'h81},
    {1'b0, 3'd6, 8'h00, 8'h00},
    {1'b1, 3'd6, 8'h00, 8'h00},
    {1'b0, 3'd2, 8'h5A, 8'h00},
    {1'b1, 3'd6, 8'h00, 8'h01},
    {1'b1, 3'd1, 8'hC3, 8'hC3},
    {1'b1, 3'd3, 8'h3C, 8'h3C},
    {1'b0, 3'd5, 8'hFF, 8'h00},
    {1'b1, 3'd5, 8'h00, 8'h14},
    {1'b1, 3'd4, 8'h00, 8'h93}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // returns the read byte; checks strobe and valid timing on the way
  task automatic rd(input logic [2:0] a, input logic [7:0] din, output logic [7:0] q);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a; nand_io_in = din;
    #1 check("R5 rd strobe", {7'd0, nand_rd_stb}, {7'd0, (a[2] == 1'b0)});
    @(negedge clk);
    host_rd = 1'b0;
    check("R9 rvalid", {7'd0, host_rvalid}, 8'd1);
    q = host_rdata;
    @(negedge clk);
    check("R9 rvalid drop", {7'd0, host_rvalid}, 8'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cle", {7'd0, nand_cle}, 8'd0);
    check("R1 ale", {7'd0, nand_ale}, 8'd0);
    check("R1 wp", {7'd0, nand_wp}, 8'd0);
    check("R1 ce_n", {7'd0, nand_ce_n}, 8'd1);
    check("R1 irq", {7'd0, host_irq}, 8'd0);
    check("R1 ecc_clr", {7'd0, ecc_clr}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd4, 8'h00, q); check("R1 mode", q, 8'h00);
    rd(3'd6, 8'h00, q); check("R1 isr", q, 8'h00);
    rd(3'd7, 8'h00, q); check("R1 imr", q, 8'h00);

    // vector table: R2 R4 R5 R6 R8 readbacks
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], VEC[i][15:8], q);
        check($sformatf("R2/R5/R6/R8 vec %0d", i), q, VEC[i][7:0]);
      end else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R2 pins from mode 0x93
    check("R2 pins", {4'd0, nand_wp, nand_ce_n, nand_ale, nand_cle}, 8'b0000_1011);
    wr(3'd4, 8'h10);
    check("R2 pins sel only", {4'd0, nand_wp, nand_ce_n, nand_ale, nand_cle}, 8'b0000_0000);
    wr(3'd4, 8'h82);
    check("R2 pins ale wp", {4'd0, nand_wp, nand_ce_n, nand_ale, nand_cle}, 8'b0000_1110);

    // R3 ECC clear strobe
    wr(3'd4, 8'h60);
    check("R3 clr on reset cmd", {7'd0, ecc_clr}, 8'd1);
    check("R3 ecc_cmd", {6'd0, ecc_cmd}, 8'd3);
    @(negedge clk);
    check("R3 clr one cycle", {7'd0, ecc_clr}, 8'd0);
    wr(3'd4, 8'h20);
    check("R3 clr on enable cmd", {7'd0, ecc_clr}, 8'd1);
    wr(3'd4, 8'h40);
    check("R3 no clr on read cmd", {7'd0, ecc_clr}, 8'd0);
    check("R3 ecc_cmd read", {6'd0, ecc_cmd}, 8'd2);
    wr(3'd4, 8'h00);
    check("R3 no clr on idle cmd", {7'd0, ecc_clr}, 8'd0);

    // R4 data write strobe and bus
    wr(3'd6, 8'h00);
    wr(3'd0, 8'hA7);
    check("R4 wr stb", {7'd0, nand_wr_stb}, 8'd1);
    check("R4 io out", nand_io_out, 8'hA7);
    @(negedge clk);
    check("R4 wr stb one cycle", {7'd0, nand_wr_stb}, 8'd0);
    rd(3'd6, 8'h00, q); check("R4 isr bit0", q, 8'h01);

    // R7 interrupt gating (isr = 0x01 now)
    wr(3'd7, 8'h81);
    check("R7 irq master+match", {7'd0, host_irq}, 8'd1);
    wr(3'd7, 8'h01);
    check("R7 irq no master", {7'd0, host_irq}, 8'd0);
    wr(3'd7, 8'h80);
    check("R7 irq no match", {7'd0, host_irq}, 8'd0);
    wr(3'd7, 8'h81);
    check("R7 irq again", {7'd0, host_irq}, 8'd1);
    // R8 status clear drops interrupt
    wr(3'd6, 8'h00);
    check("R8 isr clear irq", {7'd0, host_irq}, 8'd0);
    wr(3'd6, 8'h80);
    check("R8 isr direct set irq", {7'd0, host_irq}, 8'd1);

    // R6 write to status offset leaves pins and interrupt alone
    wr(3'd4, 8'h93);
    wr(3'd5, 8'h00);
    check("R6 pins untouched", {3'd0, host_irq, nand_wp, nand_ce_n, nand_ale, nand_cle}, 8'b0001_1011);
    check("R6 no strobe", {6'd0, ecc_clr, nand_wr_stb}, 8'd0);

    finish_run();
  end

endmodule